// File: doc/BRIEF.md
# Serial Interrupt Status Aggregator

This block gathers one-cycle event pulses from the parts of an asynchronous serial controller and latches them into an 8-bit status register. The events come from the receiver, the transmitter, the timer and the modem-control line. An 8-bit mask selects which recorded events may interrupt the host. The block then drives three things: a combinational pending indication, a registered active-high interrupt line, and the index of the highest-priority unmasked event as a vector.

The host reads the register with a one-cycle strobe. The read returns the contents from before the clear, and every bit is cleared in that cycle. The transmit-ready event can also be retired without a read: when its vector is the one on the output and the host acknowledges the vector, only that bit is cleared. A visibility control chooses what happens to masked events. With the control low, masked events are dropped. With it high, they are recorded, but they stay hidden from the interrupt, the pending indication and the vector.

The interrupt line comes from a two-state machine. In state ST_IDLE the line is low. The transition RISE moves the machine to ST_RAISED when any unmasked bit is pending. The transition FALL returns it to ST_IDLE when nothing unmasked is pending. In both states, holding the current state is the transition HOLD.

Top module: `sis_aggregator`

## Requirements
- R1: After reset the status register reads 0x00, and irq_o, pending_o and vec_valid_o are all 0.
- R2: A pulse on evt_i[k] sets status bit k at the next clock edge. The bit map is: 7 break, 6 break ended, 5 all sent, 4 XOFF match, 3 timer expired, 2 CTS change, 1 XON match, 0 transmit ready.
- R3: rd_data_o always shows the status register. In a cycle with rd_i=1 it carries the pre-clear contents, and every bit is cleared at the following edge.
- R4: An event pulse in the same cycle as rd_i=1 is kept. After that edge the register holds exactly the bits of that pulse.
- R5: With vis_i=0, an event whose mask_i bit is 1 (1 means masked) is not recorded.
- R6: With vis_i=1, a masked event is recorded. It does not set pending_o, irq_o or vec_valid_o.
- R7: pending_o is 1 in the same cycle that any bit of (status AND NOT mask) is 1. irq_o follows pending_o one clock later, both when it rises and when it falls.
- R8: vec_valid_o equals pending_o. vec_id_o is the index of the highest set unmasked bit, where bit 7 has the highest priority.
- R9: ack_i=1 while vec_valid_o=1 and vec_id_o=0 clears status bit 0 only. ack_i while any other vector is shown leaves the register unchanged.
- R10: Clearing the mask bit of a recorded masked event makes it pending in that same cycle, with its vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | One-cycle event pulses, one per status bit |
| mask_i | input | 8 | Interrupt mask, 1 = masked |
| vis_i | input | 1 | 1 = record masked events |
| rd_i | input | 1 | One-cycle host read strobe, clears all bits |
| ack_i | input | 1 | Vector acknowledge |
| rd_data_o | output | 8 | Status register contents |
| irq_o | output | 1 | Registered interrupt request |
| pending_o | output | 1 | Any unmasked status bit set |
| vec_valid_o | output | 1 | A vector is being offered |
| vec_id_o | output | 3 | Index of the highest-priority unmasked bit |

## Verification
The assertions take for granted that rd_i is high for a single cycle only. They also assume that ack_i is used only to retire the vector currently offered, and that evt_i carries pulses rather than levels. The bench drives all inputs on the falling edge. It raises rd_i and ack_i for exactly one cycle, and returns evt_i to zero after one cycle. Mask and visibility changes are made between pulses. Each event therefore falls under a single known mask setting.

// File: rtl/sis_pkg.sv
package sis_pkg;
    localparam int SRC_N = 8;
    localparam int VEC_W = $clog2(SRC_N);

    typedef logic [SRC_N-1:0] sis_bits_t;
    typedef logic [VEC_W-1:0] sis_vec_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RAISED = 1'b1
    } sis_state_t;
endpackage

// File: rtl/sis_capture.sv
module sis_capture
    import sis_pkg::*;
#(
    parameter int TXR_IDX = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  sis_bits_t evt_i,
    input  sis_bits_t mask_i,
    input  logic      vis_i,
    input  logic      rd_i,
    input  logic      ack_hit_i,
    output sis_bits_t status_o
);
    sis_bits_t status_q;
    sis_bits_t set_vec;
    sis_bits_t clr_vec;

    always_comb begin
        set_vec = vis_i ? evt_i : (evt_i & ~mask_i);
        clr_vec = '0;
        if (rd_i) begin
            clr_vec = '1;
        end else if (ack_hit_i) begin
            clr_vec[TXR_IDX] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
        end
    end

    assign status_o = status_q;

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && evt_i == '0) |=> (status_q == '0));

    // R4
    read_keeps_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && vis_i) |=> (status_q == $past(evt_i)));

    // R5
    masked_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !vis_i) |=> ((status_q & $past(mask_i)) == '0));

    // R9
    ack_clears_txr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit_i && !rd_i && !evt_i[TXR_IDX]) |=> !status_q[TXR_IDX]);
endmodule

// File: rtl/sis_prio.sv
module sis_prio
    import sis_pkg::*;
(
    input  sis_bits_t status_i,
    input  sis_bits_t mask_i,
    output logic      any_o,
    output sis_vec_t  vec_o
);
    sis_bits_t live;

    always_comb begin
        live  = status_i & ~mask_i;
        any_o = 1'b0;
        vec_o = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (live[i]) begin
                any_o = 1'b1;
                vec_o = sis_vec_t'(i);
            end
        end
    end

    // R8
    always_comb begin
        if (any_o) begin
            vec_is_live_chk: assert (status_i[vec_o] && !mask_i[vec_o]);
        end
    end
endmodule

// File: rtl/sis_irq_fsm.sv
module sis_irq_fsm
    import sis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);
    sis_state_t state_q;
    sis_state_t state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (pending_i)  state_n = ST_RAISED;
            ST_RAISED: if (!pending_i) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RAISED: irq_o = 1'b1;
            default:   irq_o = 1'b0;
        endcase
    end

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> irq_o);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !irq_o);
endmodule

// File: rtl/sis_aggregator.sv
module sis_aggregator
    import sis_pkg::*;
#(
    parameter int TXR_IDX = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] evt_i,
    input  logic [7:0] mask_i,
    input  logic       vis_i,
    input  logic       rd_i,
    input  logic       ack_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o,
    output logic       pending_o,
    output logic       vec_valid_o,
    output logic [2:0] vec_id_o
);
    localparam sis_vec_t TXR_ID = sis_vec_t'(TXR_IDX);

    sis_bits_t status;
    logic      any_live;
    sis_vec_t  vec_id;
    logic      ack_hit;

    assign ack_hit = ack_i && any_live && (vec_id == TXR_ID);

    sis_capture #(.TXR_IDX(TXR_IDX)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .mask_i   (mask_i),
        .vis_i    (vis_i),
        .rd_i     (rd_i),
        .ack_hit_i(ack_hit),
        .status_o (status)
    );

    sis_prio u_prio (
        .status_i(status),
        .mask_i  (mask_i),
        .any_o   (any_live),
        .vec_o   (vec_id)
    );

    sis_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending_i(any_live),
        .irq_o    (irq_o)
    );

    assign rd_data_o   = status;
    assign pending_o   = any_live;
    assign vec_valid_o = any_live;
    assign vec_id_o    = vec_id;

    // R6
    masked_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data_o & ~mask_i) == '0) |-> (!pending_o && !vec_valid_o));

    // R9
    ack_other_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && vec_valid_o && vec_id_o != TXR_ID && !rd_i && evt_i == '0)
        |=> (rd_data_o == $past(rd_data_o)));
endmodule

// File: tb/sis_aggregator_test.sv
module sis_aggregator_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic [7:0] mask_i = '0;
    logic       vis_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       ack_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;
    logic       pending_o;
    logic       vec_valid_o;
    logic [2:0] vec_id_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sis_aggregator uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_i(mask_i),
        .vis_i(vis_i), .rd_i(rd_i), .ack_i(ack_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o), .pending_o(pending_o), .vec_valid_o(vec_valid_o),
        .vec_id_o(vec_id_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk) evt_i = v;
        @(negedge clk) evt_i = '0;
    endtask

    task automatic host_read(input logic [7:0] exp_data, input string req);
        @(negedge clk) rd_i = 1'b1;
        #0.1 check(req, rd_data_o, exp_data);
        @(negedge clk) rd_i = 1'b0;
        check(req, rd_data_o, 0);
    endtask

    task automatic t_reset;
        check("R1 status", rd_data_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 pending", pending_o, 0);
        check("R1 valid", vec_valid_o, 0);
    endtask

    task automatic t_bitmap;
        for (int k = 0; k < 8; k++) begin
            pulse(8'(1 << k));
            check("R2 bit", rd_data_o, 1 << k);
            check("R8 vec", vec_id_o, k);
            host_read(8'(1 << k), "R3 read");
        end
    endtask

    task automatic t_prio;
        pulse(8'h15);
        check("R8 vec high", vec_id_o, 4);
        check("R8 valid", vec_valid_o, 1);
        @(negedge clk) mask_i = 8'h10;
        #0.1 check("R8 vec masked", vec_id_o, 2);
        @(negedge clk) mask_i = 8'h00;
        host_read(8'h15, "R3 read");
    endtask

    task automatic t_read_collide;
        pulse(8'h40);
        @(negedge clk) begin rd_i = 1'b1; evt_i = 8'h02; end
        #0.1 check("R4 pre", rd_data_o, 8'h40);
        @(negedge clk) begin rd_i = 1'b0; evt_i = '0; end
        check("R4 kept", rd_data_o, 8'h02);
        host_read(8'h02, "R4 read");
    endtask

    task automatic t_vis_off;
        @(negedge clk) begin vis_i = 1'b0; mask_i = 8'h80; end
        pulse(8'h81);
        check("R5 dropped", rd_data_o, 8'h01);
        @(negedge clk) mask_i = 8'h00;
        host_read(8'h01, "R5 read");
    endtask

    task automatic t_vis_on;
        @(negedge clk) begin vis_i = 1'b1; mask_i = 8'h80; end
        pulse(8'h80);
        check("R6 recorded", rd_data_o, 8'h80);
        check("R6 pending", pending_o, 0);
        check("R6 valid", vec_valid_o, 0);
        @(negedge clk);
        check("R6 irq", irq_o, 0);
        @(negedge clk) mask_i = 8'h00;
        #0.1 check("R10 pending", pending_o, 1);
        check("R10 vec", vec_id_o, 7);
        @(negedge clk) vis_i = 1'b0;
        host_read(8'h80, "R10 read");
    endtask

    task automatic t_irq_timing;
        pulse(8'h08);
        check("R7 pending", pending_o, 1);
        check("R7 irq lag", irq_o, 0);
        @(negedge clk);
        check("R7 irq up", irq_o, 1);
        @(negedge clk) rd_i = 1'b1;
        @(negedge clk) rd_i = 1'b0;
        check("R7 pending off", pending_o, 0);
        check("R7 irq hold", irq_o, 1);
        @(negedge clk);
        check("R7 irq down", irq_o, 0);
    endtask

    task automatic t_ack;
        pulse(8'h01);
        check("R9 vec0", vec_id_o, 0);
        @(negedge clk) ack_i = 1'b1;
        @(negedge clk) ack_i = 1'b0;
        check("R9 cleared", rd_data_o, 0);
        pulse(8'h03);
        check("R9 vec1", vec_id_o, 1);
        @(negedge clk) ack_i = 1'b1;
        @(negedge clk) ack_i = 1'b0;
        check("R9 other", rd_data_o, 8'h03);
        host_read(8'h03, "R9 read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_bitmap();
        t_prio();
        t_read_collide();
        t_vis_off();
        t_vis_on();
        t_irq_timing();
        t_ack();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule